// File: doc/BRIEF.md
# Asynchronous SRAM interface controller

This block lets a clocked host read and write an external asynchronous static memory of 32768 bytes. The host presents one request at a time on a valid/ready port. Each request carries a direction flag, a word address and, for writes, the byte to store. The controller then drives the memory's active-low chip-select, write-strobe and output-enable lines, its address bus and a bidirectional data bus. The data bus is split into an outgoing value, an incoming value and a drive-enable, so that the pad ring can build the tri-state buffer.

The memory has no clock, so every timing rule is met by counting controller clock cycles. The read wait is derived from the clock period and the memory's access time, rounded up to whole cycles. Address setup, write-strobe width, post-write hold and the read-to-write bus turnaround are each set by their own cycle count. All strobes come straight from flops, so they cannot glitch. A write is framed by the overlap of chip-select low and write-strobe low. The write strobe always rises before address, data or chip-select change. The data driver is never on while the memory may be driving the bus.

Top module: `sram_async_ctrl`

## Requirements
- R1: While the controller is idle, `host_ready` is 1, `mem_cs_n`, `mem_wr_n` and `mem_rd_n` are all 1, and `mem_dq_oe` is 0. This is also the state right after reset.
- R2: A request is taken on a rising clock edge where `host_valid` and `host_ready` are both 1. Direction, address and write data are captured at that edge. Later changes on the host request inputs do not affect the access in progress.
- R3: `host_ready` goes low for the cycles that follow acceptance. The count is exactly RD_CYC for a read. For a write it is WS_CYC + WP_CYC + WH_CYC, plus TA_CYC when the previous access was a read.
- R4: A read holds `mem_cs_n` = 0, `mem_rd_n` = 0, `mem_wr_n` = 1 and the captured address for RD_CYC cycles, where RD_CYC = ceil(ACC_NS / CLK_NS). `mem_dq_i` is sampled on the clock edge that ends the last of these cycles.
- R5: Read data appears on `host_rdata` with `host_rvalid` = 1 for exactly one cycle. This is the first cycle in which `host_ready` is 1 again.
- R6: A write first holds `mem_cs_n` = 0, `mem_wr_n` = 1 and `mem_dq_oe` = 1 for WS_CYC cycles. It then holds `mem_wr_n` = 0 for exactly WP_CYC cycles. Address and data stay at the captured values throughout.
- R7: The write ends with `mem_wr_n` rising while `mem_cs_n` stays 0. Address and data stay driven for WH_CYC more cycles. Only then do `mem_cs_n` rise and `mem_dq_oe` fall, both in the same cycle.
- R8: `mem_dq_oe` is never 1 while `mem_rd_n` is 0, and `mem_rd_n` and `mem_wr_n` are never 0 together.
- R9: When a write follows a read, at least TA_CYC + 1 cycles pass between `mem_rd_n` rising and `mem_dq_oe` rising. TA_CYC of those cycles are an inserted gap with every strobe high and the driver off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Request present |
| host_ready | output | 1 | Controller can take a request |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Word address |
| host_wdata | input | DATA_W | Byte to write |
| host_rvalid | output | 1 | One-cycle read-data strobe |
| host_rdata | output | DATA_W | Byte read |
| mem_cs_n | output | 1 | Memory chip-select, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| mem_rd_n | output | 1 | Memory output enable, active low |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dq_o | output | DATA_W | Data driven toward the memory |
| mem_dq_i | input | DATA_W | Data received from the memory |
| mem_dq_oe | output | 1 | Drive enable for the data pads |

## Verification
The bench builds the controller with ADDR_W = 4, CLK_NS = 4, ACC_NS = 10, WS_CYC = 1, WP_CYC = 2, WH_CYC = 1 and TA_CYC = 2. With a 16-word memory, every address can be written, read back, overwritten and read again through plain, interleaved and descending sweeps. The 10/4 access ratio tests the rounding-up of the read wait to 3 cycles. The memory model returns the complement of the stored byte until that wait has elapsed, so a capture one cycle early is caught. A two-cycle turnaround makes the inserted gap distinct from the single idle cycle that every access already has.

// File: rtl/sac_pkg.sv
package sac_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_READ   = 3'd1,
        ST_TURN   = 3'd2,
        ST_WSETUP = 3'd3,
        ST_WPULSE = 3'd4,
        ST_WHOLD  = 3'd5
    } sac_state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sac_timer.sv
module sac_timer #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sac_rd_capture.sv
module sac_rd_capture #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          valid
);

    typedef struct packed {
        logic [DW-1:0] data;
        logic          vld;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d     = cap_q;
        cap_d.vld = cap;
        if (cap) cap_d.data = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '{data: '0, vld: 1'b0};
        else        cap_q <= cap_d;
    end

    assign dout  = cap_q.data;
    assign valid = cap_q.vld;

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sac_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8,
    parameter int CLK_NS = 10,
    parameter int ACC_NS = 70,
    parameter int WS_CYC = 1,
    parameter int WP_CYC = 6,
    parameter int WH_CYC = 1,
    parameter int TA_CYC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_valid,
    output logic              host_ready,
    input  logic              host_write,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_rvalid,
    output logic [DATA_W-1:0] host_rdata,
    output logic              mem_cs_n,
    output logic              mem_wr_n,
    output logic              mem_rd_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic              mem_dq_oe
);

    // Read wait rounded up to whole clock cycles
    localparam int RD_CYC = (ACC_NS + CLK_NS - 1) / CLK_NS;
    localparam int MAX_C  = imax(imax(RD_CYC, WS_CYC), imax(imax(WP_CYC, WH_CYC), TA_CYC));
    localparam int TW     = $clog2(MAX_C + 1) + 1;

    typedef struct packed {
        sac_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              last_rd;
        logic              cs_n;
        logic              wr_n;
        logic              rd_n;
        logic              dq_oe;
    } ctrl_t;

    ctrl_t          ctrl_d, ctrl_q;
    logic           t_load;
    logic [TW-1:0]  t_val;
    logic           t_exp;
    logic           cap_now;

    sac_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_exp)
    );

    sac_rd_capture #(.DW(DATA_W)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .cap   (cap_now),
        .din   (mem_dq_i),
        .dout  (host_rdata),
        .valid (host_rvalid)
    );

    always_comb begin
        ctrl_d  = ctrl_q;
        t_load  = 1'b0;
        t_val   = '0;
        cap_now = 1'b0;
        unique case (ctrl_q.st)
            ST_IDLE: begin
                if (host_valid) begin
                    ctrl_d.addr  = host_addr;
                    ctrl_d.wdata = host_wdata;
                    t_load       = 1'b1;
                    if (host_write) begin
                        ctrl_d.last_rd = 1'b0;
                        if (ctrl_q.last_rd) begin
                            ctrl_d.st = ST_TURN;
                            t_val     = TW'(TA_CYC - 1);
                        end else begin
                            ctrl_d.st    = ST_WSETUP;
                            t_val        = TW'(WS_CYC - 1);
                            ctrl_d.cs_n  = 1'b0;
                            ctrl_d.dq_oe = 1'b1;
                        end
                    end else begin
                        ctrl_d.st      = ST_READ;
                        t_val          = TW'(RD_CYC - 1);
                        ctrl_d.last_rd = 1'b1;
                        ctrl_d.cs_n    = 1'b0;
                        ctrl_d.rd_n    = 1'b0;
                    end
                end
            end
            ST_READ: begin
                if (t_exp) begin
                    cap_now     = 1'b1;
                    ctrl_d.st   = ST_IDLE;
                    ctrl_d.cs_n = 1'b1;
                    ctrl_d.rd_n = 1'b1;
                end
            end
            ST_TURN: begin
                if (t_exp) begin
                    ctrl_d.st    = ST_WSETUP;
                    t_load       = 1'b1;
                    t_val        = TW'(WS_CYC - 1);
                    ctrl_d.cs_n  = 1'b0;
                    ctrl_d.dq_oe = 1'b1;
                end
            end
            ST_WSETUP: begin
                if (t_exp) begin
                    ctrl_d.st   = ST_WPULSE;
                    t_load      = 1'b1;
                    t_val       = TW'(WP_CYC - 1);
                    ctrl_d.wr_n = 1'b0;
                end
            end
            ST_WPULSE: begin
                if (t_exp) begin
                    ctrl_d.st   = ST_WHOLD;
                    t_load      = 1'b1;
                    t_val       = TW'(WH_CYC - 1);
                    ctrl_d.wr_n = 1'b1;
                end
            end
            ST_WHOLD: begin
                if (t_exp) begin
                    ctrl_d.st    = ST_IDLE;
                    ctrl_d.cs_n  = 1'b1;
                    ctrl_d.dq_oe = 1'b0;
                end
            end
            default: begin
                ctrl_d.st    = ST_IDLE;
                ctrl_d.cs_n  = 1'b1;
                ctrl_d.wr_n  = 1'b1;
                ctrl_d.rd_n  = 1'b1;
                ctrl_d.dq_oe = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{st: ST_IDLE, addr: '0, wdata: '0, last_rd: 1'b0,
                        cs_n: 1'b1, wr_n: 1'b1, rd_n: 1'b1, dq_oe: 1'b0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign host_ready = (ctrl_q.st == ST_IDLE);
    assign mem_cs_n   = ctrl_q.cs_n;
    assign mem_wr_n   = ctrl_q.wr_n;
    assign mem_rd_n   = ctrl_q.rd_n;
    assign mem_addr   = ctrl_q.addr;
    assign mem_dq_o   = ctrl_q.wdata;
    assign mem_dq_oe  = ctrl_q.dq_oe;

    // ---------------- checker state and assertions ----------------
    localparam int WLW = $clog2(WP_CYC + 2) + 1;
    localparam int ROW = $clog2(TA_CYC + 3) + 1;
    localparam logic [WLW-1:0] WL_MAX = '1;
    localparam logic [ROW-1:0] RO_MAX = '1;

    logic [WLW-1:0] wlow_d, wlow_q;   // cycles the write strobe has been low
    logic [ROW-1:0] rdoff_d, rdoff_q; // cycles the output enable has been high

    always_comb begin
        wlow_d  = mem_wr_n ? '0 : ((wlow_q == WL_MAX) ? wlow_q : wlow_q + 1'b1);
        rdoff_d = !mem_rd_n ? '0 : ((rdoff_q == RO_MAX) ? rdoff_q : rdoff_q + 1'b1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wlow_q  <= '0;
            rdoff_q <= RO_MAX;
        end else begin
            wlow_q  <= wlow_d;
            rdoff_q <= rdoff_d;
        end
    end

    a_r1_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |-> (mem_cs_n && mem_wr_n && mem_rd_n && !mem_dq_oe));

    a_r3_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && host_ready) |=> !host_ready);

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |=> !host_rvalid);

    a_r5_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |-> (host_ready && mem_rd_n && !$past(mem_rd_n)));

    a_r6_min_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_n) |-> (int'(wlow_q) >= WP_CYC));

    a_r7_strobe_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_n) |-> (mem_dq_oe && !mem_cs_n && $stable(mem_addr) && $stable(mem_dq_o)));

    a_r8_no_fight: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_rd_n);

    a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_rd_n && !mem_wr_n));

    a_r9_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (int'(rdoff_q) >= TA_CYC + 1));

endmodule

// File: tb/sram_async_ctrl_bench.sv
module sram_async_ctrl_bench;

    localparam int AW  = 4;
    localparam int DW  = 8;
    localparam int CK  = 4;
    localparam int ACC = 10;
    localparam int WS  = 1;
    localparam int WP  = 2;
    localparam int WH  = 1;
    localparam int TA  = 2;
    localparam int RD  = (ACC + CK - 1) / CK;
    localparam int NW  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          host_valid, host_ready, host_write, host_rvalid;
    logic [AW-1:0] host_addr, mem_addr;
    logic [DW-1:0] host_wdata, host_rdata, mem_dq_o, mem_dq_i;
    logic          mem_cs_n, mem_wr_n, mem_rd_n, mem_dq_oe;

    always #2 clk = ~clk;

    sram_async_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .CLK_NS(CK), .ACC_NS(ACC),
        .WS_CYC(WS), .WP_CYC(WP), .WH_CYC(WH), .TA_CYC(TA)
    ) u_sram_async_ctrl (
        .clk(clk), .rst_n(rst_n),
        .host_valid(host_valid), .host_ready(host_ready), .host_write(host_write),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rvalid(host_rvalid), .host_rdata(host_rdata),
        .mem_cs_n(mem_cs_n), .mem_wr_n(mem_wr_n), .mem_rd_n(mem_rd_n),
        .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_i(mem_dq_i),
        .mem_dq_oe(mem_dq_oe)
    );

    // ---------------- memory model ----------------
    logic [DW-1:0] dev_mem [NW];
    logic [DW-1:0] exp_mem [NW];
    int            rd_age = 0;
    int            fights = 0;
    logic          prev_wr = 1'b0;
    logic          dev_drv;

    assign dev_drv  = !mem_cs_n && !mem_rd_n && mem_wr_n;
    // returns the complement until the access time has elapsed
    assign mem_dq_i = (dev_drv && rd_age >= RD) ? dev_mem[mem_addr] : ~dev_mem[mem_addr];

    always @(negedge clk) begin
        if (rst_n) begin
            rd_age <= dev_drv ? rd_age + 1 : 0;
            if (prev_wr && !(!mem_cs_n && !mem_wr_n))
                dev_mem[mem_addr] <= mem_dq_oe ? mem_dq_o : ~mem_dq_o;
            prev_wr <= !mem_cs_n && !mem_wr_n;
            if (dev_drv && mem_dq_oe) fights <= fights + 1;
            if (!mem_rd_n && !mem_wr_n) fights <= fights + 1;
        end
    end

    // ---------------- checking ----------------
    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;
    bit last_rd = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int p, input int a);
        return DW'(a * 29 + p * 71 + 3);
    endfunction

    // called just after a negedge with host_ready high
    task automatic op(input bit wr, input int a, input logic [DW-1:0] d);
        int busy = 0, setup = 0, pulse = 0, hold = 0, turn = 0, rdl = 0, bad = 0;
        bit early_v = 1'b0;
        int exp_busy;
        check(host_ready === 1'b1, "R1 ready before request", host_ready, 1);
        host_valid = 1'b1;
        host_write = wr;
        host_addr  = AW'(a);
        host_wdata = d;
        @(posedge clk);
        #1;
        host_valid = 1'b0;
        host_write = !wr;          // R2: scramble after acceptance
        host_addr  = ~AW'(a);
        host_wdata = ~d;
        forever begin
            @(negedge clk);
            if (host_ready) break;
            busy++;
            if (host_rvalid) early_v = 1'b1;
            if (wr) begin
                if (mem_cs_n && mem_wr_n && mem_rd_n && !mem_dq_oe) turn++;
                else if (!mem_cs_n && mem_wr_n && mem_rd_n && mem_dq_oe) begin
                    if (pulse == 0) setup++; else hold++;
                end else if (!mem_cs_n && !mem_wr_n && mem_rd_n && mem_dq_oe) pulse++;
                else bad++;
                if (!mem_cs_n && (mem_addr !== AW'(a) || mem_dq_o !== d)) bad++;
            end else begin
                if (!mem_cs_n && !mem_rd_n && mem_wr_n && !mem_dq_oe && mem_addr === AW'(a)) rdl++;
                else bad++;
            end
        end
        exp_busy = wr ? (WS + WP + WH + (last_rd ? TA : 0)) : RD;
        check(busy == exp_busy, "R3 busy cycles", busy, exp_busy);
        check(bad == 0, wr ? "R6 write strobes/addr/data" : "R4 read strobes/addr", bad, 0);
        check(!early_v, "R5 no valid while busy", early_v, 0);
        check(mem_cs_n && mem_wr_n && mem_rd_n && !mem_dq_oe, "R1 idle strobes after access",
              {mem_cs_n, mem_wr_n, mem_rd_n, mem_dq_oe}, 4'b1110);
        if (wr) begin
            check(setup == WS, "R6 setup cycles", setup, WS);
            check(pulse == WP, "R6 pulse cycles", pulse, WP);
            check(hold == WH, "R7 hold cycles", hold, WH);
            check(turn == (last_rd ? TA : 0), "R9 turnaround gap", turn, last_rd ? TA : 0);
            check(host_rvalid == 1'b0, "R5 no valid on write", host_rvalid, 0);
            exp_mem[a] = d;
            last_rd = 1'b0;
        end else begin
            check(rdl == RD, "R4 read cycles", rdl, RD);
            check(host_rvalid == 1'b1, "R5 valid pulse", host_rvalid, 1);
            check(host_rdata == exp_mem[a], "R2/R4 read data", host_rdata, exp_mem[a]);
            last_rd = 1'b1;
        end
    endtask

    initial begin
        for (int i = 0; i < NW; i++) begin
            dev_mem[i] = '0;
            exp_mem[i] = '0;
        end
        rst_n      = 1'b0;
        host_valid = 1'b0;
        host_write = 1'b0;
        host_addr  = '0;
        host_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(host_ready && mem_cs_n && mem_wr_n && mem_rd_n && !mem_dq_oe && !host_rvalid,
              "R1 reset state", {host_ready, mem_cs_n, mem_wr_n, mem_rd_n, mem_dq_oe, host_rvalid},
              6'b111100);

        // pass 0: fill, then read all
        for (int a = 0; a < NW; a++) op(1'b1, a, pat(0, a));
        for (int a = 0; a < NW; a++) op(1'b0, a, 8'h00);
        // pass 1: read, overwrite (turnaround), read back
        for (int a = 0; a < NW; a++) begin
            op(1'b0, a, 8'h00);
            op(1'b1, a, pat(1, a));
            op(1'b0, a, 8'h00);
        end
        // pass 2: descending writes back to back, then ascending reads
        for (int a = NW - 1; a >= 0; a--) op(1'b1, a, pat(2, a));
        for (int a = 0; a < NW; a++) op(1'b0, a, 8'h00);

        check(fights == 0, "R8 bus contention or strobe overlap", fights, 0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule